// File: doc/BRIEF.md
# Masked Interrupt Priority Vectoring Unit

This unit holds one pending bit for each interrupt line of a processor core. An update port sets or clears the bit of a single line, so that each bit follows the level of its source. The pending bits are combined with a per-line enable mask to form an enabled-pending word. The highest-numbered bit that is set in that word wins arbitration. The unit turns the winner into a handler entry address: a base address, plus the sum of a fixed external-interrupt code offset and the winning index, times a selectable vector spacing. A spacing selector of zero places every vector on the base address. Any other selector value k gives a spacing of 4 << k bytes.

A request to the core is raised only when the global interrupt enable is set, the core is not in debug mode, and at least one enabled line is pending. With the default parameters there are 13 lines, packed from bit 0: bits 0-1 are software lines, bits 2-9 hardware lines, bit 10 the timer, bit 11 the inter-processor line and bit 12 the performance line. The update port can name indices 0 to 31, and any index from 13 upward is dropped. A small state machine sorts each cycle into one of three states:
- ST_QUIET: no enabled pending line.
- ST_GATED: an enabled line is pending, but the global enable is clear or debug mode is set.
- ST_RAISE: the request is raised.

The next state depends only on the current inputs. Every state moves to ST_QUIET when the enabled-pending word is zero. It moves to ST_GATED when the gates block, and otherwise to ST_RAISE. The request is asserted exactly in ST_RAISE.

Top module: `irq_vector_unit`

## Requirements
- R1: When `line_wr` is 1 and `line_num` is below 13, bit `line_num` of `pend_status` equals `line_lvl` one cycle later. All other bits are unchanged.
- R2: A write with `line_num` of 13 or more changes no pending bit, and neither does a cycle with `line_wr` at 0.
- R3: `int_req` is 1 one cycle after a cycle in which `glb_ie` is 1, `dbg_mode` is 0 and `pend_status & en_mask` is nonzero. In every other case it is 0 one cycle later.
- R4: `win_idx` is the index of the highest-numbered set bit of `pend_status & en_mask`, registered one cycle later.
- R5: When `spacing_sel` is 0 and an enabled line is pending, `target_addr` equals `base_addr` one cycle later.
- R6: When `spacing_sel` is k > 0 and an enabled line is pending, `target_addr` equals `base_addr + (64 + win_idx) * (4 << k)`, modulo 2^32, one cycle later.
- R7: During and right after reset, `pend_status`, `int_req`, `win_idx` and `target_addr` are all zero.
- R8: `win_idx` and `target_addr` follow the winner even while the request is blocked by `glb_ie` or `dbg_mode`. Both are 0 one cycle after a cycle with no enabled pending line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_wr | input | 1 | Update strobe for one pending bit |
| line_num | input | 5 | Index of the line being updated |
| line_lvl | input | 1 | New level for that line |
| en_mask | input | 13 | Per-line enable mask |
| base_addr | input | 32 | Handler base address |
| spacing_sel | input | 3 | Vector spacing selector (0 = all vectors on base) |
| glb_ie | input | 1 | Global interrupt enable |
| dbg_mode | input | 1 | Core is in debug mode (blocks requests) |
| pend_status | output | 13 | Pending-status bits |
| int_req | output | 1 | Interrupt request to the core |
| win_idx | output | 4 | Index of the winning line |
| target_addr | output | 32 | Handler entry address for the winner |

## Verification
A pending bit changes one clock edge after its write. The request, index and address are registered from the pending bits as they stood before that edge, so they change one edge after any mask, gate or spacing change, and two edges after a line write. The bench drives every input on the falling edge. Its behavioural model advances on the rising edge using the same sampled values and the same two-stage latency. All outputs are compared on the next falling edge, so every expectation sits exactly in the cycle in which the design's registers take the new value.

// File: rtl/ivu_pkg.sv
package ivu_pkg;

    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_GATED = 2'd1,
        ST_RAISE = 2'd2
    } ivu_state_e;

endpackage

// File: rtl/ivu_pending.sv
module ivu_pending #(
    parameter int NUM_LINES = 13,
    parameter int LNUM_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [LNUM_W-1:0]    num,
    input  logic                 lvl,
    output logic [NUM_LINES-1:0] pend
);

    // one flop per line; a number outside 0..NUM_LINES-1 matches no bit
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_bit
        logic hit;
        assign hit = wr && (num == LNUM_W'(g));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[g] <= 1'b0;
            end else if (hit) begin
                pend[g] <= lvl;
            end
        end
    end

endmodule

// File: rtl/ivu_prio.sv
module ivu_prio #(
    parameter int NUM_LINES = 13,
    parameter int IDX_W     = 4
) (
    input  logic [NUM_LINES-1:0] masked,
    output logic                 any,
    output logic [IDX_W-1:0]     idx
);

    // ascending scan: the last set bit seen is the highest-numbered one
    always_comb begin
        idx = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (masked[i]) begin
                idx = IDX_W'(i);
            end
        end
        any = |masked;
    end

endmodule

// File: rtl/ivu_vector.sv
module ivu_vector #(
    parameter int ADDR_W   = 32,
    parameter int SPACE_W  = 3,
    parameter int IDX_W    = 4,
    parameter int CODE_OFS = 64
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [SPACE_W-1:0] sel,
    input  logic [IDX_W-1:0]   idx,
    output logic [ADDR_W-1:0]  addr
);

    localparam int SHIFT_W = SPACE_W + 2;

    logic [ADDR_W-1:0]  slot;
    logic [SHIFT_W-1:0] shamt;

    assign slot  = ADDR_W'(CODE_OFS) + ADDR_W'(idx);
    // spacing (1 << sel) * 4 is a left shift by sel + 2
    assign shamt = SHIFT_W'(sel) + SHIFT_W'(2);

    always_comb begin
        if (sel == '0) begin
            addr = base;
        end else begin
            addr = base + (slot << shamt);
        end
    end

endmodule

// File: rtl/ivu_ctrl.sv
module ivu_ctrl
    import ivu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any,
    input  logic [IDX_W-1:0]  idx_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              glb_ie,
    input  logic              dbg_mode,
    output logic              req,
    output logic [IDX_W-1:0]  win_idx,
    output logic [ADDR_W-1:0] target_addr
);

    ivu_state_e state_q, state_d;
    logic       open_gate;

    assign open_gate = glb_ie && !dbg_mode;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (any) state_d = open_gate ? ST_RAISE : ST_GATED;
            end
            ST_GATED: begin
                if (!any)          state_d = ST_QUIET;
                else if (open_gate) state_d = ST_RAISE;
            end
            ST_RAISE: begin
                if (!any)           state_d = ST_QUIET;
                else if (!open_gate) state_d = ST_GATED;
            end
            default: state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_idx     <= '0;
            target_addr <= '0;
        end else begin
            win_idx     <= any ? idx_in  : '0;
            target_addr <= any ? addr_in : '0;
        end
    end

    assign req = (state_q == ST_RAISE);

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
    parameter int NUM_LINES = 13,
    parameter int LNUM_W    = 5,
    parameter int ADDR_W    = 32,
    parameter int SPACE_W   = 3,
    parameter int CODE_OFS  = 64,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_wr,
    input  logic [LNUM_W-1:0]    line_num,
    input  logic                 line_lvl,
    input  logic [NUM_LINES-1:0] en_mask,
    input  logic [ADDR_W-1:0]    base_addr,
    input  logic [SPACE_W-1:0]   spacing_sel,
    input  logic                 glb_ie,
    input  logic                 dbg_mode,
    output logic [NUM_LINES-1:0] pend_status,
    output logic                 int_req,
    output logic [IDX_W-1:0]     win_idx,
    output logic [ADDR_W-1:0]    target_addr
);

    logic [NUM_LINES-1:0] masked;
    logic                 any;
    logic [IDX_W-1:0]     idx_c;
    logic [ADDR_W-1:0]    addr_c;

    ivu_pending #(.NUM_LINES(NUM_LINES), .LNUM_W(LNUM_W)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (line_wr),
        .num  (line_num),
        .lvl  (line_lvl),
        .pend (pend_status)
    );

    assign masked = pend_status & en_mask;

    ivu_prio #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_prio (
        .masked(masked),
        .any   (any),
        .idx   (idx_c)
    );

    ivu_vector #(.ADDR_W(ADDR_W), .SPACE_W(SPACE_W), .IDX_W(IDX_W), .CODE_OFS(CODE_OFS)) u_vec (
        .base(base_addr),
        .sel (spacing_sel),
        .idx (idx_c),
        .addr(addr_c)
    );

    ivu_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .any        (any),
        .idx_in     (idx_c),
        .addr_in    (addr_c),
        .glb_ie     (glb_ie),
        .dbg_mode   (dbg_mode),
        .req        (int_req),
        .win_idx    (win_idx),
        .target_addr(target_addr)
    );

endmodule

// File: rtl/ivu_chk.sv
module ivu_chk #(
    parameter int NUM_LINES = 13,
    parameter int LNUM_W    = 5,
    parameter int ADDR_W    = 32,
    parameter int SPACE_W   = 3,
    parameter int IDX_W     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 line_wr,
    input logic [LNUM_W-1:0]    line_num,
    input logic                 line_lvl,
    input logic [NUM_LINES-1:0] en_mask,
    input logic [ADDR_W-1:0]    base_addr,
    input logic [SPACE_W-1:0]   spacing_sel,
    input logic                 glb_ie,
    input logic                 dbg_mode,
    input logic [NUM_LINES-1:0] pend_status,
    input logic                 int_req,
    input logic [IDX_W-1:0]     win_idx,
    input logic [ADDR_W-1:0]    target_addr
);

    logic [NUM_LINES-1:0] prev_masked;
    always_ff @(posedge clk) begin
        if (!rst_n) prev_masked <= '0;
        else        prev_masked <= pend_status & en_mask;
    end

    // R1
    pend_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_wr && line_num < LNUM_W'(NUM_LINES)) |=> pend_status[$past(line_num)] == $past(line_lvl));

    // R2
    pend_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_wr || line_num >= LNUM_W'(NUM_LINES)) |=> $stable(pend_status));

    // R3
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> ($past(glb_ie) && !$past(dbg_mode) && prev_masked != '0));

    // R4
    winner_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> ((prev_masked >> win_idx) == NUM_LINES'(1)));

    // R5
    flat_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && $past(spacing_sel) == '0) |-> target_addr == $past(base_addr));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_masked == '0) |-> (win_idx == '0 && target_addr == '0 && !int_req));

endmodule

bind irq_vector_unit ivu_chk #(
    .NUM_LINES(NUM_LINES), .LNUM_W(LNUM_W), .ADDR_W(ADDR_W),
    .SPACE_W(SPACE_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .line_wr(line_wr), .line_num(line_num),
    .line_lvl(line_lvl), .en_mask(en_mask), .base_addr(base_addr),
    .spacing_sel(spacing_sel), .glb_ie(glb_ie), .dbg_mode(dbg_mode),
    .pend_status(pend_status), .int_req(int_req), .win_idx(win_idx),
    .target_addr(target_addr)
);

// File: tb/tb_irq_vector_unit.sv
module tb_irq_vector_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_wr = 1'b0;
    logic [4:0]  line_num = '0;
    logic        line_lvl = 1'b0;
    logic [12:0] en_mask = '0;
    logic [31:0] base_addr = '0;
    logic [2:0]  spacing_sel = '0;
    logic        glb_ie = 1'b0;
    logic        dbg_mode = 1'b0;
    logic [12:0] pend_status;
    logic        int_req;
    logic [3:0]  win_idx;
    logic [31:0] target_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    irq_vector_unit dut (
        .clk(clk), .rst_n(rst_n), .line_wr(line_wr), .line_num(line_num),
        .line_lvl(line_lvl), .en_mask(en_mask), .base_addr(base_addr),
        .spacing_sel(spacing_sel), .glb_ie(glb_ie), .dbg_mode(dbg_mode),
        .pend_status(pend_status), .int_req(int_req), .win_idx(win_idx),
        .target_addr(target_addr)
    );

    // behavioural reference model
    int          m_pend [13];
    bit          m_req;
    int          m_idx;
    logic [31:0] m_addr;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            foreach (m_pend[i]) m_pend[i] = 0;
            m_req = 0; m_idx = 0; m_addr = '0;
        end else begin
            int top;
            longint spc;
            top = -1;
            for (int i = 12; i >= 0; i--) begin
                if (m_pend[i] != 0 && en_mask[i]) begin
                    top = i;
                    break;
                end
            end
            spc = (spacing_sel == 0) ? 0 : (longint'(1) << spacing_sel) * 4;
            if (top < 0) begin
                m_req = 0; m_idx = 0; m_addr = '0;
            end else begin
                m_req  = glb_ie && !dbg_mode;
                m_idx  = top;
                m_addr = 32'(longint'(base_addr) + (64 + top) * spc);
            end
            if (line_wr && line_num < 13) m_pend[line_num] = line_lvl;
        end
    end

    function automatic logic [12:0] model_pend();
        logic [12:0] v;
        for (int i = 0; i < 13; i++) v[i] = (m_pend[i] != 0);
        return v;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        check("R1 pending", pend_status, model_pend());
        check("R3 request", int_req, m_req);
        check("R4 index", win_idx, m_idx);
        check("R6 address", target_addr, m_addr);
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic put(input int n, input bit l);
        line_wr = 1'b1; line_num = 5'(n); line_lvl = l;
        step();
        line_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset pend", pend_status, 0);
        check("R7 reset req", int_req, 0);
        check("R7 reset addr", target_addr, 0);
        rst_n = 1'b1;
        step();
        check("R7 after reset idx", win_idx, 0);

        // directed: lines 3 and 7, all enabled, flat spacing
        en_mask = '1; glb_ie = 1'b1; base_addr = 32'h0000_1000; spacing_sel = 3'd0;
        put(3, 1'b1);
        put(7, 1'b1);
        step();
        check("R4 highest wins", win_idx, 7);
        check("R5 flat vector", target_addr, 32'h1000);
        check("R3 request up", int_req, 1);

        // R2: out-of-range writes leave pending untouched
        put(20, 1'b1);
        step();
        check("R2 oor ignored", pend_status, 13'h0088);
        put(13, 1'b1);
        step();
        check("R2 index 13 ignored", pend_status, 13'h0088);

        // R6: spacing 2 -> 16 bytes
        spacing_sel = 3'd2;
        step();
        check("R6 spaced vector", target_addr, 32'h1000 + (64 + 7) * 16);

        // R8: gated by debug mode, index stays
        dbg_mode = 1'b1;
        step();
        check("R3 debug blocks", int_req, 0);
        check("R8 index while gated", win_idx, 7);
        dbg_mode = 1'b0; glb_ie = 1'b0;
        step();
        check("R3 ie blocks", int_req, 0);
        glb_ie = 1'b1;

        // mask line 7 -> line 3 wins; clear line 3 -> nothing
        en_mask = 13'h1F7F;
        step();
        check("R4 mask lowers winner", win_idx, 3);
        put(3, 1'b0);
        step();
        check("R8 idle index", win_idx, 0);
        check("R8 idle address", target_addr, 0);

        // randomised traffic, model compared every cycle
        for (int k = 0; k < 3000; k++) begin
            line_wr  = $urandom_range(0, 1) == 1;
            line_num = 5'($urandom_range(0, 15));
            line_lvl = $urandom_range(0, 2) != 0;
            if ($urandom_range(0, 15) == 0) en_mask = 13'($urandom);
            if ($urandom_range(0, 7) == 0) spacing_sel = 3'($urandom);
            if ($urandom_range(0, 31) == 0) base_addr = $urandom & 32'hFFFF_F000;
            glb_ie   = $urandom_range(0, 7) != 0;
            dbg_mode = $urandom_range(0, 15) == 0;
            step();
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule